// File: doc/BRIEF.md
# Forward Command/Data Byte Transmitter for an Extended-Capability Parallel Port

This block is the host-side sender of a forward-direction byte stream on an extended-capability parallel port. A host-side queue presents one word at a time over a valid/ready pair. Each word is a tag bit plus an 8-bit byte. The tag marks the byte as either plain data or a command. The block places the byte on the eight parallel data lines. It sets the command/data flag line to match the tag, waits a programmable setup time, and then raises a strobe. It holds everything steady until the peripheral has acknowledged the byte and released that acknowledge.

The block copies command bytes to the lines without change. Bit 7 of a command byte selects how the peripheral reads the low seven bits. A clear bit 7 means a run-length count in the range 0 to 127. A set bit 7 means a channel address in the range 0 to 127. When no transfer is in progress, the strobe is low and the command/data flag is parked high.

Top module: `ecp_fwd_tx`

## Requirements
- R1: After reset, `host_stb` is 0, `cd_flag` is 1 and `in_ready` is 1 (with `periph_ack` low).
- R2: A word with tag bit `in_word[8]` = 0 (plain data) is sent with `cd_flag` = 1, and `par_data` equals `in_word[7:0]`.
- R3: A word with tag bit `in_word[8]` = 1 (command) is sent with `cd_flag` = 0, and `par_data` equals `in_word[7:0]`.
- R4: A command whose bit 7 is 0 (a run-length count, bits 6..0 = 0..127) reaches `par_data` unchanged, including the values 0x00 and 0x7F.
- R5: A command whose bit 7 is 1 (a channel address, bits 6..0 = 0..127) reaches `par_data` unchanged, including the values 0x80 and 0xFF.
- R6: `par_data` and `cd_flag` take their new values in the cycle after acceptance. They stay constant until the acknowledge is released. `host_stb` stays low for exactly `SETUP_CYC` cycles after acceptance before it rises.
- R7: `host_stb` stays high until `periph_ack` is sampled high, and it falls on the next clock edge.
- R8: `in_ready` is 0 from acceptance until `periph_ack` has been sampled low after the strobe falls. A word held valid during that time is not taken, and it does not disturb the lines.
- R9: Once a transfer completes, the block returns to idle with `host_stb` = 0 and `cd_flag` = 1, even after a command, and `in_ready` = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Queue has a word to send |
| in_ready | output | 1 | Block takes the word on this edge |
| in_word | input | 9 | Bit 8: 1 = command, 0 = data; bits 7..0: byte |
| par_data | output | 8 | Parallel data lines |
| cd_flag | output | 1 | High = data byte, low = command byte |
| host_stb | output | 1 | Byte-present strobe, active high |
| periph_ack | input | 1 | Peripheral acknowledge, active high |

## Verification
The bench sends both tags and command bytes at each edge of the run-length and channel-address ranges. A design that swapped the flag polarity, or masked bit 7, would show the wrong `cd_flag` level or a corrupted byte. For every transfer, the bench counts the strobe-low cycles after acceptance. A design that skipped or lengthened the setup window would give the wrong count. It also holds a second word valid while the acknowledge is still high. A block that took the next word early, or that dropped the strobe before the acknowledge, would change the lines or the strobe in a window where they must stay fixed. After a command, it checks that the flag goes back to its parked high level.

// File: rtl/ecp_tx_pkg.sv
package ecp_tx_pkg;

    localparam int OCTET_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SETUP   = 2'd1,
        ST_STROBE  = 2'd2,
        ST_RELEASE = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic               dflag;
        logic [OCTET_W-1:0] octet;
    } lines_t;

    typedef struct packed {
        tx_state_e state;
        logic      stb;
        lines_t    lines;
    } ctl_t;

endpackage

// File: rtl/ecp_tx_encode.sv
module ecp_tx_encode
    import ecp_tx_pkg::*;
(
    input  logic [OCTET_W:0] word,
    output lines_t           lines
);
    // Tag bit above the byte: 1 = command (flag low), 0 = data (flag high).
    always_comb begin
        lines.dflag = ~word[OCTET_W];
        lines.octet = word[OCTET_W-1:0];
    end
endmodule

// File: rtl/ecp_tx_setup_timer.sv
module ecp_tx_setup_timer #(
    parameter int SETUP_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic run,
    output logic expired
);
    localparam int CW = (SETUP_CYC < 2) ? 1 : $clog2(SETUP_CYC);
    localparam logic [CW-1:0] START = CW'(SETUP_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = START;
        else if (run && cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);

    // R6
    setup_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/ecp_fwd_tx.sv
module ecp_fwd_tx
    import ecp_tx_pkg::*;
#(
    parameter int SETUP_CYC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [8:0]   in_word,
    output logic [7:0]   par_data,
    output logic         cd_flag,
    output logic         host_stb,
    input  logic         periph_ack
);
    ctl_t   c_d, c_q;
    lines_t enc_lines;
    logic   accept;
    logic   setup_done;

    ecp_tx_encode enc_i (
        .word  (in_word),
        .lines (enc_lines)
    );

    ecp_tx_setup_timer #(.SETUP_CYC(SETUP_CYC)) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .run     (c_q.state == ST_SETUP),
        .expired (setup_done)
    );

    always_comb begin
        c_d      = c_q;
        in_ready = (c_q.state == ST_IDLE) && !periph_ack;
        accept   = in_valid && in_ready;
        unique case (c_q.state)
            ST_IDLE: begin
                c_d.stb         = 1'b0;
                c_d.lines.dflag = 1'b1;
                if (accept) begin
                    c_d.lines = enc_lines;
                    c_d.state = ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (setup_done) begin
                    c_d.stb   = 1'b1;
                    c_d.state = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (periph_ack) begin
                    c_d.stb   = 1'b0;
                    c_d.state = ST_RELEASE;
                end
            end
            ST_RELEASE: begin
                if (!periph_ack) begin
                    c_d.lines.dflag = 1'b1;
                    c_d.state       = ST_IDLE;
                end
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state       <= ST_IDLE;
            c_q.stb         <= 1'b0;
            c_q.lines.dflag <= 1'b1;
            c_q.lines.octet <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign par_data = c_q.lines.octet;
    assign cd_flag  = c_q.lines.dflag;
    assign host_stb = c_q.stb;

    // R2 R3
    accept_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (par_data == $past(in_word[7:0]))
                                   && (cd_flag == !$past(in_word[8])));
    // R6
    stable_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_stb || c_q.state == ST_RELEASE) |-> ($stable(par_data) && $stable(cd_flag)));
    // R6
    no_early_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !host_stb);
    // R7
    stb_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_stb) |-> $past(periph_ack));
    // R9
    idle_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (cd_flag && !host_stb));
endmodule

// File: tb/ecp_fwd_tx_tb.sv
module ecp_fwd_tx_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SETUP_N    = 2;
    localparam int WDOG_CYC   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [8:0] in_word = '0;
    logic [7:0] par_data;
    logic       cd_flag;
    logic       host_stb;
    logic       periph_ack = 1'b0;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecp_fwd_tx #(.SETUP_CYC(SETUP_N)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_word    (in_word),
        .par_data   (par_data),
        .cd_flag    (cd_flag),
        .host_stb   (host_stb),
        .periph_ack (periph_ack)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
        end
    endtask

    task automatic xfer(input logic tag, input logic [7:0] oct, input int ack_wait, input string rq);
        logic exp_flag;
        int   low;
        exp_flag = ~tag;
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = {tag, oct};
        chk(in_ready == 1'b1, "R9 ready before send", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(par_data == oct, {rq, " byte on lines"}, int'(par_data), int'(oct));
        chk(cd_flag == exp_flag, {rq, " flag level"}, int'(cd_flag), int'(exp_flag));
        chk(in_ready == 1'b0, "R8 busy after accept", int'(in_ready), 0);
        low = 1;
        while (!host_stb && low < 50) begin
            @(negedge clk);
            if (!host_stb) low++;
        end
        chk(low == SETUP_N, "R6 setup cycles", low, SETUP_N);
        for (int i = 0; i < ack_wait; i++) begin
            chk(host_stb == 1'b1, "R7 strobe held", int'(host_stb), 1);
            chk(par_data == oct && cd_flag == exp_flag, "R6 lines stable",
                int'({cd_flag, par_data}), int'({exp_flag, oct}));
            @(negedge clk);
        end
        periph_ack = 1'b1;
        @(negedge clk);
        chk(host_stb == 1'b0, "R7 strobe falls after ack", int'(host_stb), 0);
        chk(in_ready == 1'b0, "R8 not ready while ack high", int'(in_ready), 0);
        @(negedge clk);
        chk(par_data == oct && cd_flag == exp_flag, "R6 lines held in release",
            int'({cd_flag, par_data}), int'({exp_flag, oct}));
        periph_ack = 1'b0;
        #1;
        chk(in_ready == 1'b0, "R8 not ready before ack low sampled", int'(in_ready), 0);
        @(negedge clk);
        chk(in_ready == 1'b1 && cd_flag == 1'b1 && host_stb == 1'b0, "R9 idle park",
            int'({in_ready, cd_flag, host_stb}), 3'b110);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(host_stb == 1'b0, "R1 strobe low", int'(host_stb), 0);
        chk(cd_flag == 1'b1, "R1 flag high", int'(cd_flag), 1);
        chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    endtask

    task automatic test_data();
        xfer(1'b0, 8'h5A, 0, "R2");
        xfer(1'b0, 8'hA5, 3, "R2");
    endtask

    task automatic test_runlen();
        xfer(1'b1, 8'h05, 1, "R3 R4");
        xfer(1'b1, 8'h00, 2, "R4 min count");
        xfer(1'b1, 8'h7F, 0, "R4 max count");
    endtask

    task automatic test_channel();
        xfer(1'b1, 8'h80, 1, "R5 min channel");
        xfer(1'b1, 8'hFF, 4, "R5 max channel");
    endtask

    task automatic test_held_valid();
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = {1'b1, 8'h83};
        @(negedge clk);
        in_word  = {1'b0, 8'h3C};
        chk(par_data == 8'h83 && cd_flag == 1'b0, "R3 first word", int'(par_data), 8'h83);
        while (!host_stb) @(negedge clk);
        @(negedge clk);
        chk(par_data == 8'h83, "R8 held word ignored in strobe", int'(par_data), 8'h83);
        periph_ack = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(par_data == 8'h83 && cd_flag == 1'b0, "R8 held word ignored while ack high",
            int'({cd_flag, par_data}), 9'h083);
        periph_ack = 1'b0;
        @(negedge clk);
        chk(in_ready == 1'b1 && cd_flag == 1'b1, "R9 idle before second",
            int'({in_ready, cd_flag}), 2'b11);
        @(negedge clk);
        in_valid = 1'b0;
        chk(par_data == 8'h3C && cd_flag == 1'b1, "R8 second word taken after release",
            int'({cd_flag, par_data}), 9'h13C);
        while (!host_stb) @(negedge clk);
        periph_ack = 1'b1;
        @(negedge clk);
        periph_ack = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(in_ready == 1'b1, "R9 idle at end", int'(in_ready), 1);
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=<%0d", WDOG_CYC, WDOG_CYC);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_data();
        test_runlen();
        test_channel();
        test_held_valid();
        repeat (2) @(negedge clk);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule